// File: doc/BRIEF.md
# Two-Channel Linear CCD Drive Sequencer

This block produces every digital clock that a two-output linear CCD sensor needs during one line, all derived from a single fast system clock. It drives a transfer-gate pulse, and for each of the two readout channels it drives a pair of complementary shift clocks, a last-stage clock, a reset-gate clock and a clamp clock. A line begins when a trigger arrives in the idle state. The block first holds the shift clocks still through a leading guard interval, then asserts the transfer gate, and then holds still through a trailing guard interval. After that it clocks out a configured number of pixels per channel.

Two configuration choices are captured when the trigger is accepted. Per-pixel clamping places one reset pulse and then one clamp pulse in every pixel period. Per-line clamping instead pulses the clamp clock once, between the trailing guard and the first pixel, and keeps it low during readout. The second channel either copies the first exactly or runs half a pixel period ahead of it. Every duration is a clock-cycle count set by a parameter. A line trigger that arrives while a line is in progress is dropped and counted in a saturating counter.

Top module: `ccd_line_timer`

## Requirements
- R1: While reset is asserted and after its release, the outputs rest at their idle values: transfer gate 0, phase-1 clock 1, phase-2 clock 0, last-stage clock 0, reset gate 0, clamp 0, busy 0 and overrun count 0. Every output is registered, so a change in internal state reaches the pins one clock later.
- R2: A trigger taken in idle starts a leading guard of GUARD_CYC cycles with the gate low. The gate is then high for GATE_CYC cycles, followed by a trailing guard of GUARD_CYC cycles. Throughout this sequence the phase-1 clocks stay high and the phase-2 and last-stage clocks stay low.
- R3: On both channels the reset gate and clamp clocks are low through the leading guard, the gate pulse and the trailing guard.
- R4: Readout lasts exactly the captured pixel count times 2*HALF_CYC cycles. Within a pixel the phase index runs from 0 to 2*HALF_CYC-1. Phase-1 is high for indices below HALF_CYC, phase-2 is its complement, and the last-stage clock equals phase-2.
- R5: In per-pixel clamp mode (cfg_line_clamp=0), the reset gate is high for phase indices below RST_CYC. The clamp is high for the next CLP_CYC indices and low for all others.
- R6: In per-line clamp mode (cfg_line_clamp=1), both clamp clocks are high for CLP_CYC cycles directly after the trailing guard, with the shift clocks idle and the reset gates low. They stay low throughout readout, while the reset gates still pulse as in R5.
- R7: With cfg_out_of_phase=0, every channel-2 clock equals the corresponding channel-1 clock in every cycle.
- R8: With cfg_out_of_phase=1, channel 2 follows the rules of R4 and R5 using phase index (p+HALF_CYC) mod 2*HALF_CYC, where p is channel 1's index.
- R9: The busy output is high from the first leading-guard cycle through the last readout cycle, and the block then returns to idle.
- R10: A trigger that arrives while the sequencer is not idle is ignored. It increments the overrun count, which saturates at 2^OVR_W-1.
- R11: The clamp mode, the phase mode and the pixel count are captured when a trigger is accepted. Changing them during a line has no effect on that line.
- R12: A captured pixel count of 0 skips readout, so the line ends after the trailing guard, or after the line clamp pulse in per-line mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_trig | input | 1 | Line start request, sampled each clock |
| cfg_line_clamp | input | 1 | 1 = clamp once per line, 0 = clamp every pixel |
| cfg_out_of_phase | input | 1 | 1 = channel 2 runs half a pixel ahead |
| cfg_npix | input | NPIX_W | Pixels per channel per line |
| tg | output | 1 | Transfer gate |
| ch1_p1 | output | 1 | Channel 1 phase-1 shift clock |
| ch1_p2 | output | 1 | Channel 1 phase-2 shift clock |
| ch1_last | output | 1 | Channel 1 last-stage clock |
| ch1_rst | output | 1 | Channel 1 reset gate |
| ch1_clp | output | 1 | Channel 1 clamp clock |
| ch2_p1 | output | 1 | Channel 2 phase-1 shift clock |
| ch2_p2 | output | 1 | Channel 2 phase-2 shift clock |
| ch2_last | output | 1 | Channel 2 last-stage clock |
| ch2_rst | output | 1 | Channel 2 reset gate |
| ch2_clp | output | 1 | Channel 2 clamp clock |
| line_busy | output | 1 | Line in progress |
| overrun_cnt | output | OVR_W | Saturating count of ignored triggers |

## Verification
The bench builds the block with HALF_CYC=3, GATE_CYC=6, GUARD_CYC=2, RST_CYC=2, CLP_CYC=1, NPIX_W=4 and OVR_W=3. With these values a whole line lasts only a few dozen cycles, so every output can be compared cycle by cycle across many lines. The odd half period makes the half-pixel skew fall across the reset-to-clamp boundary, which tests the wrap of the skewed phase. The three-bit overrun counter reaches its saturation value after a handful of stray triggers.

// File: rtl/ccd_timer_pkg.sv
package ccd_timer_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_GATE,
    SQ_TRAIL,
    SQ_LCLP,
    SQ_READ
  } seq_state_e;

  // Channel bundle bit positions
  localparam int unsigned W_P1  = 4;
  localparam int unsigned W_P2  = 3;
  localparam int unsigned W_LST = 2;
  localparam int unsigned W_RST = 1;
  localparam int unsigned W_CLP = 0;

endpackage

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_timer_pkg::*;
#(
  parameter int unsigned HALF_CYC  = 3,
  parameter int unsigned GATE_CYC  = 200,
  parameter int unsigned GUARD_CYC = 40,
  parameter int unsigned CLP_CYC   = 1,
  parameter int unsigned NPIX_W    = 13,
  localparam int unsigned PER_CYC  = 2 * HALF_CYC,
  localparam int unsigned PH_W     = (PER_CYC > 2) ? $clog2(PER_CYC) : 1,
  localparam int unsigned MAX_T    = (GATE_CYC > GUARD_CYC) ?
                                     ((GATE_CYC > CLP_CYC) ? GATE_CYC : CLP_CYC) :
                                     ((GUARD_CYC > CLP_CYC) ? GUARD_CYC : CLP_CYC),
  localparam int unsigned TMR_W    = $clog2(MAX_T + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              cfg_lc,
  input  logic              cfg_sk,
  input  logic [NPIX_W-1:0] cfg_np,
  output seq_state_e        state,
  output logic [PH_W-1:0]   phase,
  output logic              lc_q,
  output logic              sk_q,
  output logic              trig_lost
);

  localparam logic [TMR_W-1:0] GUARD_END = TMR_W'(GUARD_CYC - 1);
  localparam logic [TMR_W-1:0] GATE_END  = TMR_W'(GATE_CYC - 1);
  localparam logic [TMR_W-1:0] CLP_END   = TMR_W'(CLP_CYC - 1);
  localparam logic [PH_W-1:0]  PH_END    = PH_W'(PER_CYC - 1);

  seq_state_e        st_q, st_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [NPIX_W-1:0] pix_q, pix_d;
  logic [NPIX_W-1:0] np_q;
  logic              cfg_ld;
  logic              tmr_en, rd_en;
  logic              np_zero;

  assign np_zero = (np_q == '0);

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q + 1'b1;
    ph_d   = ph_q;
    pix_d  = pix_q;
    cfg_ld = 1'b0;
    tmr_en = 1'b1;
    rd_en  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        tmr_d = '0;
        if (trig) begin
          st_d   = SQ_LEAD;
          cfg_ld = 1'b1;
        end
      end
      SQ_LEAD: begin
        if (tmr_q == GUARD_END) begin
          st_d  = SQ_GATE;
          tmr_d = '0;
        end
      end
      SQ_GATE: begin
        if (tmr_q == GATE_END) begin
          st_d  = SQ_TRAIL;
          tmr_d = '0;
        end
      end
      SQ_TRAIL: begin
        if (tmr_q == GUARD_END) begin
          tmr_d = '0;
          rd_en = 1'b1;
          ph_d  = '0;
          pix_d = '0;
          if (lc_q)         st_d = SQ_LCLP;
          else if (np_zero) st_d = SQ_IDLE;
          else              st_d = SQ_READ;
        end
      end
      SQ_LCLP: begin
        if (tmr_q == CLP_END) begin
          tmr_d = '0;
          st_d  = np_zero ? SQ_IDLE : SQ_READ;
        end
      end
      SQ_READ: begin
        tmr_en = 1'b0;
        rd_en  = 1'b1;
        if (ph_q == PH_END) begin
          ph_d = '0;
          if (pix_q == np_q - 1'b1) st_d  = SQ_IDLE;
          else                      pix_d = pix_q + 1'b1;
        end else begin
          ph_d = ph_q + 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      tmr_q <= '0;
      ph_q  <= '0;
      pix_q <= '0;
      lc_q  <= 1'b0;
      sk_q  <= 1'b0;
      np_q  <= '0;
    end else begin
      st_q <= st_d;
      if (tmr_en) tmr_q <= tmr_d;
      if (rd_en) begin
        ph_q  <= ph_d;
        pix_q <= pix_d;
      end
      if (cfg_ld) begin
        lc_q <= cfg_lc;
        sk_q <= cfg_sk;
        np_q <= cfg_np;
      end
    end
  end

  assign state     = st_q;
  assign phase     = ph_q;
  assign trig_lost = trig && (st_q != SQ_IDLE);

endmodule

// File: rtl/ccd_chan_wave.sv
module ccd_chan_wave
  import ccd_timer_pkg::*;
#(
  parameter int unsigned HALF_CYC = 3,
  parameter int unsigned RST_CYC  = 1,
  parameter int unsigned CLP_CYC  = 1,
  localparam int unsigned PER_CYC = 2 * HALF_CYC,
  localparam int unsigned PH_W    = (PER_CYC > 2) ? $clog2(PER_CYC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_state_e      state,
  input  logic [PH_W-1:0] phase,
  input  logic            skew,
  input  logic            line_clamp,
  output logic [4:0]      wave
);

  localparam logic [PH_W-1:0] HALF_V = PH_W'(HALF_CYC);
  localparam logic [PH_W:0]   RST_V  = (PH_W + 1)'(RST_CYC);
  localparam logic [PH_W:0]   CLPE_V = (PH_W + 1)'(RST_CYC + CLP_CYC);

  logic [PH_W-1:0] ph_eff;
  logic [PH_W:0]   ph_x;
  logic            in_read, in_lclp;
  logic [4:0]      wave_d, wave_q;

  assign in_read = (state == SQ_READ);
  assign in_lclp = (state == SQ_LCLP);

  // Half-pixel rotation of the phase index
  always_comb begin
    if (!skew)               ph_eff = phase;
    else if (phase >= HALF_V) ph_eff = phase - HALF_V;
    else                     ph_eff = phase + HALF_V;
  end
  assign ph_x = {1'b0, ph_eff};

  always_comb begin
    wave_d        = '0;
    wave_d[W_P1]  = !in_read || (ph_eff < HALF_V);
    wave_d[W_P2]  = !wave_d[W_P1];
    wave_d[W_LST] = !wave_d[W_P1];
    wave_d[W_RST] = in_read && (ph_x < RST_V);
    wave_d[W_CLP] = in_lclp ||
                    (in_read && !line_clamp && (ph_x >= RST_V) && (ph_x < CLPE_V));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 5'b10000;
    else        wave_q <= wave_d;
  end

  assign wave = wave_q;

endmodule

// File: rtl/ccd_sat_counter.sv
module ccd_sat_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  assign cnt_en = inc && (cnt_q != {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timer_pkg::*;
#(
  parameter int unsigned HALF_CYC  = 3,
  parameter int unsigned GATE_CYC  = 200,
  parameter int unsigned GUARD_CYC = 40,
  parameter int unsigned RST_CYC   = 1,
  parameter int unsigned CLP_CYC   = 1,
  parameter int unsigned NPIX_W    = 13,
  parameter int unsigned OVR_W     = 8,
  localparam int unsigned PER_CYC  = 2 * HALF_CYC,
  localparam int unsigned PH_W     = (PER_CYC > 2) ? $clog2(PER_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_trig,
  input  logic              cfg_line_clamp,
  input  logic              cfg_out_of_phase,
  input  logic [NPIX_W-1:0] cfg_npix,
  output logic              tg,
  output logic              ch1_p1,
  output logic              ch1_p2,
  output logic              ch1_last,
  output logic              ch1_rst,
  output logic              ch1_clp,
  output logic              ch2_p1,
  output logic              ch2_p2,
  output logic              ch2_last,
  output logic              ch2_rst,
  output logic              ch2_clp,
  output logic              line_busy,
  output logic [OVR_W-1:0]  overrun_cnt
);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  seq_state_e      state;
  logic [PH_W-1:0] phase;
  logic            lc_act, skew_act, trig_lost;
  logic [4:0]      wave [2];
  logic            tg_q, busy_q;

  ccd_line_seq #(
    .HALF_CYC (HALF_CYC),
    .GATE_CYC (GATE_CYC),
    .GUARD_CYC(GUARD_CYC),
    .CLP_CYC  (CLP_CYC),
    .NPIX_W   (NPIX_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (arst_n),
    .trig     (line_trig),
    .cfg_lc   (cfg_line_clamp),
    .cfg_sk   (cfg_out_of_phase),
    .cfg_np   (cfg_npix),
    .state    (state),
    .phase    (phase),
    .lc_q     (lc_act),
    .sk_q     (skew_act),
    .trig_lost(trig_lost)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    ccd_chan_wave #(
      .HALF_CYC(HALF_CYC),
      .RST_CYC (RST_CYC),
      .CLP_CYC (CLP_CYC)
    ) u_wave (
      .clk       (clk),
      .rst_n     (arst_n),
      .state     (state),
      .phase     (phase),
      .skew      ((ch == 1) ? skew_act : 1'b0),
      .line_clamp(lc_act),
      .wave      (wave[ch])
    );
  end

  ccd_sat_counter #(.CNT_W(OVR_W)) u_ovr (
    .clk  (clk),
    .rst_n(arst_n),
    .inc  (trig_lost),
    .count(overrun_cnt)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      tg_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      tg_q   <= (state == SQ_GATE);
      busy_q <= (state != SQ_IDLE);
    end
  end

  assign tg        = tg_q;
  assign line_busy = busy_q;
  assign ch1_p1    = wave[0][W_P1];
  assign ch1_p2    = wave[0][W_P2];
  assign ch1_last  = wave[0][W_LST];
  assign ch1_rst   = wave[0][W_RST];
  assign ch1_clp   = wave[0][W_CLP];
  assign ch2_p1    = wave[1][W_P1];
  assign ch2_p2    = wave[1][W_P2];
  assign ch2_last  = wave[1][W_LST];
  assign ch2_rst   = wave[1][W_RST];
  assign ch2_clp   = wave[1][W_CLP];

endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
  parameter int unsigned OVR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tg,
  input logic             line_busy,
  input logic             skew_act,
  input logic             ch1_p1,
  input logic             ch1_p2,
  input logic             ch1_last,
  input logic             ch1_rst,
  input logic             ch1_clp,
  input logic             ch2_p1,
  input logic             ch2_p2,
  input logic             ch2_last,
  input logic             ch2_rst,
  input logic             ch2_clp,
  input logic [OVR_W-1:0] overrun_cnt
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !line_busy |-> (!tg && ch1_p1 && ch2_p1 && !ch1_rst && !ch2_rst))
    else $error("idle outputs not at rest");

  assert_gate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tg |-> (ch1_p1 && ch2_p1 && !ch1_p2 && !ch2_p2))
    else $error("shift clocks moved during gate");

  assert_lead_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tg) |-> $past(line_busy))
    else $error("gate rose without leading guard");

  assert_gate_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tg |-> !(ch1_rst || ch1_clp || ch2_rst || ch2_clp))
    else $error("reset or clamp active during gate");

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch1_rst && ch1_clp) && !(ch2_rst && ch2_clp))
    else $error("reset and clamp overlap");

  assert_in_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !skew_act |-> (ch1_p1 == ch2_p1 && ch1_last == ch2_last &&
                   ch1_rst == ch2_rst && ch1_clp == ch2_clp))
    else $error("channels differ in in-phase mode");

  assert_gate_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tg |-> line_busy)
    else $error("gate outside busy window");

  assert_ovr_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_cnt >= $past(overrun_cnt))
    else $error("overrun count decreased");

endmodule

bind ccd_line_timer ccd_line_timer_chk #(.OVR_W(OVR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tg         (tg),
  .line_busy  (line_busy),
  .skew_act   (skew_act),
  .ch1_p1     (ch1_p1),
  .ch1_p2     (ch1_p2),
  .ch1_last   (ch1_last),
  .ch1_rst    (ch1_rst),
  .ch1_clp    (ch1_clp),
  .ch2_p1     (ch2_p1),
  .ch2_p2     (ch2_p2),
  .ch2_last   (ch2_last),
  .ch2_rst    (ch2_rst),
  .ch2_clp    (ch2_clp),
  .overrun_cnt(overrun_cnt)
);

// File: tb/ccd_line_timer_test.sv
`timescale 1ns/1ps
module ccd_line_timer_test;

  localparam int H  = 3;
  localparam int T  = 6;
  localparam int G  = 2;
  localparam int R  = 2;
  localparam int C  = 1;
  localparam int P  = 2 * H;
  localparam int NW = 4;
  localparam int OW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line_trig = 1'b0;
  logic          cfg_line_clamp = 1'b0;
  logic          cfg_out_of_phase = 1'b0;
  logic [NW-1:0] cfg_npix = '0;
  logic tg, ch1_p1, ch1_p2, ch1_last, ch1_rst, ch1_clp;
  logic ch2_p1, ch2_p2, ch2_last, ch2_rst, ch2_clp;
  logic line_busy;
  logic [OW-1:0] overrun_cnt;

  int checks = 0;
  int errors = 0;
  int ovr_model = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ccd_line_timer #(
    .HALF_CYC(H), .GATE_CYC(T), .GUARD_CYC(G), .RST_CYC(R), .CLP_CYC(C),
    .NPIX_W(NW), .OVR_W(OW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .line_trig(line_trig),
    .cfg_line_clamp(cfg_line_clamp), .cfg_out_of_phase(cfg_out_of_phase),
    .cfg_npix(cfg_npix), .tg(tg),
    .ch1_p1(ch1_p1), .ch1_p2(ch1_p2), .ch1_last(ch1_last),
    .ch1_rst(ch1_rst), .ch1_clp(ch1_clp),
    .ch2_p1(ch2_p1), .ch2_p2(ch2_p2), .ch2_last(ch2_last),
    .ch2_rst(ch2_rst), .ch2_clp(ch2_clp),
    .line_busy(line_busy), .overrun_cnt(overrun_cnt)
  );

  task automatic chk(input string tag, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, expv, $time);
    end
  endtask

  // Channel bundle {p1,p2,last,rst,clp} for a phase index
  function automatic logic [4:0] pix_wave(int ph, bit lc);
    logic p1;
    p1 = (ph < H);
    return {p1, !p1, !p1, ph < R, !lc && ph >= R && ph < R + C};
  endfunction

  function automatic int line_len(bit lc, int np);
    return 2 * G + T + (lc ? C : 0) + np * P;
  endfunction

  // {busy, tg, ch1[4:0], ch2[4:0]} for sequencer step s
  function automatic logic [11:0] exp_vec(int s, bit lc, bit sk, int np);
    logic [11:0] v;
    int rd0, ph;
    rd0 = 2 * G + T + (lc ? C : 0);
    v = {1'b0, 1'b0, 5'b10000, 5'b10000};
    if (s >= 0 && s < line_len(lc, np)) v[11] = 1'b1;
    if (s >= G && s < G + T) v[10] = 1'b1;
    if (lc && s >= 2 * G + T && s < rd0) begin
      v[5] = 1'b1;
      v[0] = 1'b1;
    end
    if (s >= rd0 && s < line_len(lc, np)) begin
      ph = (s - rd0) % P;
      v[9:5] = pix_wave(ph, lc);
      v[4:0] = pix_wave(sk ? (ph + H) % P : ph, lc);
    end
    return v;
  endfunction

  function automatic logic [11:0] got_vec();
    return {line_busy, tg, ch1_p1, ch1_p2, ch1_last, ch1_rst, ch1_clp,
            ch2_p1, ch2_p2, ch2_last, ch2_rst, ch2_clp};
  endfunction

  // One line; stray >= 0 drives an extra trigger at that step.
  // chg changes the configuration mid-line (R11). ovr overrides tags.
  task automatic run_line(bit lc, bit sk, int np, int stray, bit chg, string ovr);
    logic [11:0] e, g;
    int rd0, tot;
    string t_tg, t_sh, t_rs, t_cl, t_c2, t_bz;
    rd0 = 2 * G + T + (lc ? C : 0);
    tot = line_len(lc, np);
    @(negedge clk);
    cfg_line_clamp = lc;
    cfg_out_of_phase = sk;
    cfg_npix = NW'(np);
    line_trig = 1'b1;
    @(negedge clk);
    line_trig = 1'b0;
    for (int k = 0; k <= tot + 1; k++) begin
      int s;
      s = k - 1;
      e = exp_vec(s, lc, sk, np);
      g = got_vec();
      t_tg = "R2";
      t_bz = (s < 0) ? "R1" : "R9";
      if (s >= rd0 && s < tot) begin
        t_sh = "R4"; t_rs = "R5"; t_cl = lc ? "R6" : "R5";
      end else if (s >= 2 * G + T && s < rd0) begin
        t_sh = "R6"; t_rs = "R6"; t_cl = "R6";
      end else begin
        t_sh = "R2"; t_rs = "R3"; t_cl = "R3";
      end
      t_c2 = sk ? "R8" : "R7";
      if (ovr != "") begin
        t_tg = ovr; t_bz = ovr; t_sh = ovr; t_rs = ovr; t_cl = ovr; t_c2 = ovr;
      end
      chk(t_bz, int'(g[11]), int'(e[11]));
      chk(t_tg, int'(g[10]), int'(e[10]));
      chk(t_sh, int'(g[9:7]), int'(e[9:7]));
      chk(t_rs, int'(g[6]), int'(e[6]));
      chk(t_cl, int'(g[5]), int'(e[5]));
      chk(t_c2, int'(g[4:0]), int'(e[4:0]));
      line_trig = (k == stray) && (k < tot);
      if (line_trig && ovr_model < (1 << OW) - 1) ovr_model++;
      if (chg && k == 2) begin
        cfg_line_clamp = !lc;
        cfg_out_of_phase = !sk;
        cfg_npix = NW'(np + 2);
      end
      @(negedge clk);
      line_trig = 1'b0;
    end
    chk("R10", int'(overrun_cnt), ovr_model);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", int'(got_vec()), int'({2'b00, 5'b10000, 5'b10000}));
    chk("R1", int'(overrun_cnt), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", int'(got_vec()), int'({2'b00, 5'b10000, 5'b10000}));
    chk("R1", int'(overrun_cnt), 0);

    // Directed corner cases
    run_line(1'b0, 1'b0, 2, -1, 1'b0, "");
    run_line(1'b1, 1'b1, 3, -1, 1'b0, "");
    run_line(1'b0, 1'b1, 1, 0, 1'b0, "");
    run_line(1'b1, 1'b0, 0, -1, 1'b0, "R12");
    run_line(1'b0, 1'b0, 0, 3, 1'b0, "R12");
    run_line(1'b0, 1'b1, 2, -1, 1'b1, "R11");
    run_line(1'b1, 1'b0, 15, -1, 1'b0, "");
    run_line(1'b0, 1'b0, 1, line_len(1'b0, 1) - 1, 1'b0, "R10");

    // Constrained random lines
    for (int n = 0; n < 24; n++) begin
      bit lc, sk;
      int np, st;
      lc = bit'($urandom_range(0, 1));
      sk = bit'($urandom_range(0, 1));
      np = int'($urandom_range(1, 6));
      st = ($urandom_range(0, 2) == 0) ? -1 :
           int'($urandom_range(0, line_len(lc, np) - 1));
      run_line(lc, sk, np, st, bit'($urandom_range(0, 3) == 0), "");
    end

    chk("R10", int'(overrun_cnt), (1 << OW) - 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 got=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule